// File: doc/BRIEF.md
# Write-back L1 data cache with a store queue in front

This block is a direct-mapped, write-back, write-allocate first-level data cache. A small in-order store queue sits in front of it. Processor stores are written into the queue and acknowledged at once. A processor load searches the queue and the cache in the same cycle. If any queued store matches the load's word, the youngest such store supplies the data and the cache result is dropped. Otherwise a cache hit answers the load, and a miss in both starts a fetch from the next memory level.

When the miss controller is idle, a background path moves the oldest queued store into the cache. A drained store that hits updates its word and marks the line dirty. A drained store that misses goes through the normal miss sequence: write back a dirty victim, fetch the line, then merge the store. Loads use the single cache lookup port ahead of the drain. A load accepted in a cycle locks the port for that cycle only, and the drain waits. Stores touch only the queue, so they are still accepted while a miss is in progress.

Addresses are byte addresses of whole words. The byte-select bits are ignored. Index and tag come from the bits above the word offset.

Top module: `l1sb_cache`

## Requirements
- R1: A store is accepted whenever the store queue holds fewer than SB_DEPTH entries, whatever the miss state. With SB_DEPTH entries queued, req_ready is low for a store. An accepted store issues no memory request by itself.
- R2: A load whose word matches one or more queued stores returns the data of the youngest of them, with rsp_valid high in the cycle after acceptance.
- R3: A load that matches no queued store but hits in the cache returns the cached word in the cycle after acceptance and causes no memory request.
- R4: A load that misses in both the queue and the cache fetches its line with a read at the line-aligned address (mem_req_write low). After the fill it returns the word that memory supplied, with rsp_valid high in the cycle after mem_rsp_valid.
- R5: The queue drains only when the miss controller is idle and no load is accepted in that cycle. Entries leave strictly oldest first, so the last store to a word is the value the cache keeps.
- R6: A drained store that hits overwrites its word in the line and marks the line dirty. When that line is later evicted, the write-back carries the stored value.
- R7: A drained store that misses runs the miss sequence. A dirty victim is written back (mem_req_write high) before the fill read is issued. The store is then merged into the fetched line, which is left dirty.
- R8: While a miss is being handled, req_ready is low for loads.
- R9: A memory request holds mem_req_valid, mem_req_write and mem_req_addr unchanged until mem_req_ready is seen. Only one request is presented at a time.
- R10: After reset, req_ready is high, rsp_valid and mem_req_valid are low, the queue is empty and every cache line is invalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word-aligned byte address |
| req_data | input | WORD_W | Store data |
| rsp_valid | output | 1 | Load data valid (one-cycle pulse) |
| rsp_data | output | WORD_W | Load data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = line write-back, 0 = line read |
| mem_req_addr | output | ADDR_W | Line-aligned byte address |
| mem_req_line | output | WORD_W*LINE_WORDS | Write-back line data, word 0 in the low bits |
| mem_rsp_valid | input | 1 | Fill line present (one cycle) |
| mem_rsp_line | input | WORD_W*LINE_WORDS | Fill line data, word 0 in the low bits |

## Verification
On every cycle the checker enforces several rules. Drains happen only when the controller is idle and no load was accepted. Loads are refused during a miss, and stores are refused when the queue is full. A pending memory request stays stable until it is accepted, and a write-back is only ever presented ahead of its fill. Every hit and every load fill produces a response one cycle later. The data itself can only be checked by the bench's scenarios: youngest-store forwarding, oldest-first drain order, merging of a drained store into a fetched line, and the value carried by a dirty eviction. For these the bench compares each load against a flat model of memory that is updated when each store is accepted.

// File: rtl/l1sb_pkg.sv
package l1sb_pkg;
   typedef enum logic [1:0] {
      MS_IDLE  = 2'd0,
      MS_EVICT = 2'd1,
      MS_FETCH = 2'd2,
      MS_FILL  = 2'd3
   } miss_state_e;
endpackage

// File: rtl/l1sb_store_buf.sv
module l1sb_store_buf #(
   parameter int KEY_W  = 14,
   parameter int WORD_W = 32,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [KEY_W-1:0]  push_key,
   input  logic [WORD_W-1:0] push_data,
   input  logic              pop,
   input  logic [KEY_W-1:0]  look_key,
   output logic              full,
   output logic              empty,
   output logic [$clog2(DEPTH+1)-1:0] count,
   output logic [KEY_W-1:0]  head_key,
   output logic [WORD_W-1:0] head_data,
   output logic              hit,
   output logic [WORD_W-1:0] hit_data
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH+1);

   logic [KEY_W-1:0]  key_q  [DEPTH];
   logic [WORD_W-1:0] data_q [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [CNT_W-1:0]  cnt_q;
   logic [PTR_W-1:0]  age   [DEPTH];
   logic [DEPTH-1:0]  match;

   assign count     = cnt_q;
   assign full      = (cnt_q == CNT_W'(DEPTH));
   assign empty     = (cnt_q == '0);
   assign head_key  = key_q[rd_ptr];
   assign head_data = data_q[rd_ptr];

   // per-slot age relative to the oldest entry, and word match
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      assign age[i]   = PTR_W'(i) - rd_ptr;
      assign match[i] = ({1'b0, age[i]} < cnt_q) && (key_q[i] == look_key);
   end

   // youngest matching entry wins
   always_comb begin
      logic [PTR_W-1:0] best;
      hit      = 1'b0;
      hit_data = '0;
      best     = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (match[i] && (!hit || age[i] > best)) begin
            hit      = 1'b1;
            best     = age[i];
            hit_data = data_q[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         key_q[wr_ptr]  <= push_key;
         data_q[wr_ptr] <= push_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end
endmodule

// File: rtl/l1sb_tag_data.sv
module l1sb_tag_data #(
   parameter int IDX_W  = 3,
   parameter int TAG_W  = 9,
   parameter int LINE_W = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic              rd_dirty,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [LINE_W-1:0] rd_line,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [LINE_W-1:0] wr_line,
   input  logic              wr_dirty
);
   localparam int NUM = 1 << IDX_W;

   logic [NUM-1:0]    valid_q, dirty_q;
   logic [TAG_W-1:0]  tag_q  [NUM];
   logic [LINE_W-1:0] line_q [NUM];

   assign rd_valid = valid_q[rd_idx];
   assign rd_dirty = dirty_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];
   assign rd_line  = line_q[rd_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_idx] <= 1'b1;
         dirty_q[wr_idx] <= wr_dirty;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx]  <= wr_tag;
         line_q[wr_idx] <= wr_line;
      end
   end
endmodule

// File: rtl/l1sb_cache.sv
module l1sb_cache
   import l1sb_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int WORD_W     = 32,
   parameter int LINE_WORDS = 4,
   parameter int NUM_LINES  = 8,
   parameter int SB_DEPTH   = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   output logic                         req_ready,
   input  logic                         req_is_store,
   input  logic [ADDR_W-1:0]            req_addr,
   input  logic [WORD_W-1:0]            req_data,
   output logic                         rsp_valid,
   output logic [WORD_W-1:0]            rsp_data,
   output logic                         mem_req_valid,
   input  logic                         mem_req_ready,
   output logic                         mem_req_write,
   output logic [ADDR_W-1:0]            mem_req_addr,
   output logic [WORD_W*LINE_WORDS-1:0] mem_req_line,
   input  logic                         mem_rsp_valid,
   input  logic [WORD_W*LINE_WORDS-1:0] mem_rsp_line
);
   localparam int BYTE_W = $clog2(WORD_W/8);
   localparam int OFF_W  = $clog2(LINE_WORDS);
   localparam int IDX_W  = $clog2(NUM_LINES);
   localparam int KEY_W  = ADDR_W - BYTE_W;
   localparam int TAG_W  = KEY_W - OFF_W - IDX_W;
   localparam int LINE_W = WORD_W * LINE_WORDS;
   localparam int LOW_W  = OFF_W + BYTE_W;
   localparam int CNT_W  = $clog2(SB_DEPTH+1);

   // elaboration-time parameter checks
   if (WORD_W < 8 || (WORD_W & (WORD_W-1)) != 0) begin : g_bad_word
      $error("WORD_W must be a power of two of at least 8");
   end
   if (LINE_WORDS < 2 || (LINE_WORDS & (LINE_WORDS-1)) != 0) begin : g_bad_line
      $error("LINE_WORDS must be a power of two of at least 2");
   end
   if (NUM_LINES < 2 || (NUM_LINES & (NUM_LINES-1)) != 0) begin : g_bad_lines
      $error("NUM_LINES must be a power of two of at least 2");
   end
   if (SB_DEPTH < 2 || (SB_DEPTH & (SB_DEPTH-1)) != 0) begin : g_bad_depth
      $error("SB_DEPTH must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ADDR_W too small for the cache geometry");
   end

   function automatic logic [IDX_W-1:0] idx_of(input logic [KEY_W-1:0] k);
      return k[OFF_W +: IDX_W];
   endfunction
   function automatic logic [TAG_W-1:0] tag_of(input logic [KEY_W-1:0] k);
      return k[KEY_W-1 -: TAG_W];
   endfunction
   function automatic logic [OFF_W-1:0] off_of(input logic [KEY_W-1:0] k);
      return k[OFF_W-1:0];
   endfunction
   function automatic logic [WORD_W-1:0] get_word(input logic [LINE_W-1:0] l,
                                                  input logic [OFF_W-1:0]  o);
      return l[o*WORD_W +: WORD_W];
   endfunction
   function automatic logic [LINE_W-1:0] put_word(input logic [LINE_W-1:0] l,
                                                  input logic [OFF_W-1:0]  o,
                                                  input logic [WORD_W-1:0] w);
      logic [LINE_W-1:0] r;
      r = l;
      r[o*WORD_W +: WORD_W] = w;
      return r;
   endfunction

   logic [KEY_W-1:0] req_key;
   logic             unused_byte_sel;
   assign req_key         = req_addr[ADDR_W-1:BYTE_W];
   assign unused_byte_sel = ^req_addr[BYTE_W-1:0];

   // miss register
   miss_state_e       mshr_q;
   logic              miss_store_q;
   logic [KEY_W-1:0]  miss_key_q;
   logic [WORD_W-1:0] miss_data_q;

   // store queue
   logic              sb_full, sb_empty, sb_hit;
   logic [CNT_W-1:0]  sb_count;
   logic [KEY_W-1:0]  sb_head_key;
   logic [WORD_W-1:0] sb_head_data, sb_hit_data;

   // cache array interface
   logic              rd_valid, rd_dirty;
   logic [TAG_W-1:0]  rd_tag;
   logic [LINE_W-1:0] rd_line;
   logic              wr_en, wr_dirty;
   logic [IDX_W-1:0]  wr_idx;
   logic [TAG_W-1:0]  wr_tag;
   logic [LINE_W-1:0] wr_line;

   logic             load_fire, store_fire, drain_fire, port_lock;
   logic             cache_hit, mreq_free;
   logic [KEY_W-1:0] look_key;

   assign req_ready  = req_is_store ? !sb_full : (mshr_q == MS_IDLE);
   assign load_fire  = req_valid && !req_is_store && req_ready;
   assign store_fire = req_valid && req_is_store && req_ready;
   assign port_lock  = load_fire;
   assign drain_fire = (mshr_q == MS_IDLE) && !sb_empty && !port_lock;
   assign mreq_free  = !mem_req_valid || mem_req_ready;

   always_comb begin
      if (mshr_q != MS_IDLE) look_key = miss_key_q;
      else if (load_fire)    look_key = req_key;
      else                   look_key = sb_head_key;
   end

   assign cache_hit = rd_valid && (rd_tag == tag_of(look_key));

   l1sb_store_buf #(
      .KEY_W (KEY_W),
      .WORD_W(WORD_W),
      .DEPTH (SB_DEPTH)
   ) u_sbuf (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (store_fire),
      .push_key (req_key),
      .push_data(req_data),
      .pop      (drain_fire),
      .look_key (req_key),
      .full     (sb_full),
      .empty    (sb_empty),
      .count    (sb_count),
      .head_key (sb_head_key),
      .head_data(sb_head_data),
      .hit      (sb_hit),
      .hit_data (sb_hit_data)
   );

   l1sb_tag_data #(
      .IDX_W (IDX_W),
      .TAG_W (TAG_W),
      .LINE_W(LINE_W)
   ) u_arr (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (idx_of(look_key)),
      .rd_valid(rd_valid),
      .rd_dirty(rd_dirty),
      .rd_tag  (rd_tag),
      .rd_line (rd_line),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_tag  (wr_tag),
      .wr_line (wr_line),
      .wr_dirty(wr_dirty)
   );

   // single write port: drain hit (idle) or fill (waiting), never both
   always_comb begin
      wr_en    = 1'b0;
      wr_idx   = idx_of(look_key);
      wr_tag   = tag_of(look_key);
      wr_line  = rd_line;
      wr_dirty = 1'b0;
      if (drain_fire && cache_hit) begin
         wr_en    = 1'b1;
         wr_line  = put_word(rd_line, off_of(sb_head_key), sb_head_data);
         wr_dirty = 1'b1;
      end else if (mshr_q == MS_FILL && mem_rsp_valid) begin
         wr_en    = 1'b1;
         wr_idx   = idx_of(miss_key_q);
         wr_tag   = tag_of(miss_key_q);
         wr_line  = miss_store_q ? put_word(mem_rsp_line, off_of(miss_key_q), miss_data_q)
                                 : mem_rsp_line;
         wr_dirty = miss_store_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mshr_q        <= MS_IDLE;
         miss_store_q  <= 1'b0;
         miss_key_q    <= '0;
         miss_data_q   <= '0;
         rsp_valid     <= 1'b0;
         rsp_data      <= '0;
         mem_req_valid <= 1'b0;
         mem_req_write <= 1'b0;
         mem_req_addr  <= '0;
         mem_req_line  <= '0;
      end else begin
         rsp_valid <= 1'b0;
         if (mem_req_valid && mem_req_ready) mem_req_valid <= 1'b0;
         case (mshr_q)
            MS_IDLE: begin
               if (load_fire) begin
                  if (sb_hit) begin
                     rsp_valid <= 1'b1;
                     rsp_data  <= sb_hit_data;
                  end else if (cache_hit) begin
                     rsp_valid <= 1'b1;
                     rsp_data  <= get_word(rd_line, off_of(req_key));
                  end else begin
                     miss_store_q <= 1'b0;
                     miss_key_q   <= req_key;
                     mshr_q       <= MS_EVICT;
                  end
               end else if (drain_fire && !cache_hit) begin
                  miss_store_q <= 1'b1;
                  miss_key_q   <= sb_head_key;
                  miss_data_q  <= sb_head_data;
                  mshr_q       <= MS_EVICT;
               end
            end
            MS_EVICT: begin
               if (rd_valid && rd_dirty) begin
                  if (mreq_free) begin
                     mem_req_valid <= 1'b1;
                     mem_req_write <= 1'b1;
                     mem_req_addr  <= {rd_tag, idx_of(miss_key_q), {LOW_W{1'b0}}};
                     mem_req_line  <= rd_line;
                     mshr_q        <= MS_FETCH;
                  end
               end else begin
                  mshr_q <= MS_FETCH;
               end
            end
            MS_FETCH: begin
               if (mreq_free) begin
                  mem_req_valid <= 1'b1;
                  mem_req_write <= 1'b0;
                  mem_req_addr  <= {tag_of(miss_key_q), idx_of(miss_key_q), {LOW_W{1'b0}}};
                  mshr_q        <= MS_FILL;
               end
            end
            MS_FILL: begin
               if (mem_rsp_valid) begin
                  if (!miss_store_q) begin
                     rsp_valid <= 1'b1;
                     rsp_data  <= get_word(mem_rsp_line, off_of(miss_key_q));
                  end
                  mshr_q <= MS_IDLE;
               end
            end
            default: mshr_q <= MS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/l1sb_chk.sv
module l1sb_chk
   import l1sb_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int SB_DEPTH = 4
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         req_valid,
   input logic                         req_is_store,
   input logic                         req_ready,
   input logic                         rsp_valid,
   input logic                         mem_req_valid,
   input logic                         mem_req_ready,
   input logic                         mem_req_write,
   input logic [ADDR_W-1:0]            mem_req_addr,
   input logic                         mem_rsp_valid,
   input miss_state_e                  mshr,
   input logic [$clog2(SB_DEPTH+1)-1:0] sb_count,
   input logic                         sb_empty,
   input logic                         drain_fire,
   input logic                         sb_hit,
   input logic                         cache_hit,
   input logic                         miss_store
);
   // R1
   sb_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(sb_count) <= SB_DEPTH);

   // R1
   store_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_is_store && int'(sb_count) == SB_DEPTH) |-> !req_ready);

   // R8
   load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mshr != MS_IDLE && req_valid && !req_is_store) |-> !req_ready);

   // R5
   drain_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drain_fire |-> (mshr == MS_IDLE && !sb_empty && !(req_valid && !req_is_store && req_ready)));

   // R2
   hit_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_is_store && req_ready && (sb_hit || cache_hit)) |=> rsp_valid);

   // R4
   fill_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mshr == MS_FILL && mem_rsp_valid && !miss_store) |=> (rsp_valid && mshr == MS_IDLE));

   // R9
   mreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=>
         (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

   // R7
   wb_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_write) |-> mshr == MS_FETCH);
endmodule

bind l1sb_cache l1sb_chk #(
   .ADDR_W  (ADDR_W),
   .SB_DEPTH(SB_DEPTH)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_is_store (req_is_store),
   .req_ready    (req_ready),
   .rsp_valid    (rsp_valid),
   .mem_req_valid(mem_req_valid),
   .mem_req_ready(mem_req_ready),
   .mem_req_write(mem_req_write),
   .mem_req_addr (mem_req_addr),
   .mem_rsp_valid(mem_rsp_valid),
   .mshr         (mshr_q),
   .sb_count     (sb_count),
   .sb_empty     (sb_empty),
   .drain_fire   (drain_fire),
   .sb_hit       (sb_hit),
   .cache_hit    (cache_hit),
   .miss_store   (miss_store_q)
);

// File: tb/l1sb_cache_bench.sv
module l1sb_cache_bench;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 16, WORD_W = 32, LINE_WORDS = 4, NUM_LINES = 8, SB_DEPTH = 4;
   localparam int LINE_W = WORD_W * LINE_WORDS;
   localparam int NWORDS = 128;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_is_store = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [WORD_W-1:0] req_data = '0;
   logic req_ready, rsp_valid;
   logic [WORD_W-1:0] rsp_data;
   logic mem_req_valid, mem_req_write;
   logic mem_req_ready = 1'b1;
   logic [ADDR_W-1:0] mem_req_addr;
   logic [LINE_W-1:0] mem_req_line;
   logic mem_rsp_valid = 1'b0;
   logic [LINE_W-1:0] mem_rsp_line = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   l1sb_cache #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS),
                .NUM_LINES(NUM_LINES), .SB_DEPTH(SB_DEPTH)) u_l1sb_cache (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_is_store(req_is_store), .req_addr(req_addr), .req_data(req_data),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
      .mem_req_addr(mem_req_addr), .mem_req_line(mem_req_line),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_line(mem_rsp_line));

   int checks = 0, errors = 0, cycles = 0;
   logic [WORD_W-1:0] ref_mem [NWORDS];
   logic [WORD_W-1:0] backing [NWORDS];
   int rd_count = 0, wb_count = 0;
   bit fill_hold = 0, mem_rand = 0;
   bit rd_pending = 0;
   int rd_base = 0, rd_wait = 0;

   function automatic logic [WORD_W-1:0] init_word(input int w);
      return 32'h1000_0000 + 32'(w) * 32'h0001_0003;
   endfunction

   task automatic check(input string tag, input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // memory model: decides ready, records handshakes, returns fills
   always @(negedge clk) begin
      mem_rsp_valid <= 1'b0;
      if (rd_pending && !fill_hold) begin
         if (rd_wait == 0) begin
            for (int k = 0; k < LINE_WORDS; k++)
               mem_rsp_line[k*WORD_W +: WORD_W] <= backing[rd_base + k];
            mem_rsp_valid <= 1'b1;
            rd_pending = 0;
         end else rd_wait--;
      end
      mem_req_ready = mem_rand ? ($urandom % 4 != 0) : 1'b1;
      if (rst_n && mem_req_valid && mem_req_ready) begin
         if (mem_req_write) begin
            for (int k = 0; k < LINE_WORDS; k++)
               backing[(int'(mem_req_addr) >> 2) + k] = mem_req_line[k*WORD_W +: WORD_W];
            wb_count++;
         end else begin
            rd_base = int'(mem_req_addr) >> 2;
            rd_wait = mem_rand ? int'($urandom % 4) : 1;
            rd_pending = 1;
            rd_count++;
         end
      end
   end

   always @(negedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++; checks++;
         $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic wait_ready(input string tag);
      int n = 0;
      while (!req_ready && n < 2000) begin @(negedge clk); #1; n++; end
      if (!req_ready) check({tag, " ready timeout"}, 0, 1);
   endtask

   task automatic do_store(input int w, input logic [WORD_W-1:0] d);
      req_valid = 1; req_is_store = 1; req_addr = ADDR_W'(w << 2); req_data = d;
      #1; wait_ready("store");
      ref_mem[w] = d;
      @(negedge clk); req_valid = 0;
   endtask

   int last_lat;
   task automatic do_load(input int w, input string tag, input bit chk_lat);
      logic [WORD_W-1:0] exp;
      int lat = 0;
      req_valid = 1; req_is_store = 0; req_addr = ADDR_W'(w << 2);
      #1; wait_ready(tag);
      exp = ref_mem[w];
      @(negedge clk); req_valid = 0;
      while (!rsp_valid && lat < 1000) begin @(negedge clk); lat++; end
      check(tag, rsp_data, exp);
      if (chk_lat) check({tag, " latency"}, 32'(lat), 0);
      last_lat = lat;
   endtask

   initial begin
      logic [WORD_W-1:0] v [SB_DEPTH];
      logic [WORD_W-1:0] exp70;
      int rd0, wb0, n;
      void'($urandom(32'd4711));
      for (int i = 0; i < NWORDS; i++) begin
         ref_mem[i] = init_word(i);
         backing[i] = init_word(i);
      end
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk); #1;
      // R10 reset state
      check("R10 req_ready", 32'(req_ready), 1);
      check("R10 rsp_valid", 32'(rsp_valid), 0);
      check("R10 mem_req_valid", 32'(mem_req_valid), 0);

      // bring line of word 5 in, then forward from the queue (R2)
      do_load(5, "R4 cold load", 0);
      check("R4 cold load reads memory", 32'(rd_count), 1);
      do_store(5, 32'hAAAA_0001);
      do_store(5, 32'hBBBB_0002);
      do_load(5, "R2 youngest store forwarded", 1);
      repeat (10) @(negedge clk);
      // R3: hit with no memory traffic
      rd0 = rd_count;
      do_load(5, "R3 cache hit", 1);
      check("R3 no memory request", 32'(rd_count), 32'(rd0));
      // R4/R6: conflicting load evicts the dirty line holding word 5
      rd0 = rd_count; wb0 = wb_count;
      do_load(37, "R4 conflict miss", 0);
      check("R4 one fill read", 32'(rd_count), 32'(rd0 + 1));
      check("R6 dirty victim written back", 32'(wb_count), 32'(wb0 + 1));
      check("R6 write-back carries drained store", backing[5], 32'hBBBB_0002);

      // R8 and R1 while a fill is held back
      fill_hold = 1;
      req_valid = 1; req_is_store = 0; req_addr = ADDR_W'(70 << 2);
      #1; wait_ready("R8 start");
      exp70 = ref_mem[70];
      @(negedge clk); req_valid = 0;
      repeat (4) @(negedge clk);
      req_valid = 1; req_is_store = 0; req_addr = ADDR_W'(3 << 2); #1;
      check("R8 load refused during miss", 32'(req_ready), 0);
      req_valid = 0;
      for (int k = 0; k < SB_DEPTH; k++) begin
         v[k] = 32'hC0DE_0000 + 32'(k);
         do_store(9, v[k]);
      end
      req_valid = 1; req_is_store = 1; req_addr = ADDR_W'(9 << 2); req_data = 32'hDEAD_BEEF; #1;
      check("R1 store refused when queue full", 32'(req_ready), 0);
      req_valid = 0;
      fill_hold = 0;
      n = 0;
      while (!rsp_valid && n < 1000) begin @(negedge clk); n++; end
      check("R4 held fill data", rsp_data, exp70);
      repeat (60) @(negedge clk);
      // R5 oldest-first drain, R7 allocate on drained miss
      do_load(9, "R5 R7 last store survives drain", 1);
      rd0 = rd_count;
      do_load(8, "R7 merged line neighbour", 1);
      check("R7 neighbour from allocated line", 32'(rd_count), 32'(rd0));

      // constrained random mix
      mem_rand = 1;
      for (int i = 0; i < 400; i++) begin
         int w = int'($urandom % NWORDS);
         if ($urandom % 2 == 0) do_store(w, $urandom);
         else do_load(w, "R2 R3 R4 random load", 0);
         if ($urandom % 8 == 0) repeat ($urandom % 6) @(negedge clk);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule